// File: doc/BRIEF.md
# Fractional Clock Enable Generator

This block raises a single-cycle enable strobe at a rational fraction n/m of its clock rate. Downstream logic that should run slower than the clock qualifies its registers with the strobe instead of using a divided clock. The ratio is given as a pair of modulo values rather than a plain divide count. The addition value equals m − n. The subtraction value equals −n and is held as a field of W low magnitude bits whose upper bits are implied ones.

The core is a modulo accumulator that is one bit wider than the field. On every clock in which the block is running, the subtraction value is added to the accumulator. When that sum goes negative, the accumulator loads itself plus the addition value and the strobe fires for that cycle. Otherwise the accumulator keeps the sum and the strobe stays low. A small state machine sequences the block through three states. ST_OFF means the enable is low. ST_HALT means the enable is high but the setting is invalid, that is, both fields are zero. ST_RUN means it is generating strobes. The transitions are named T_START (OFF→RUN), T_REJECT (OFF→HALT), T_RECOVER (HALT→RUN), T_FAULT (RUN→HALT), and T_STOP and T_ABORT (RUN→OFF and HALT→OFF). The accumulator is cleared whenever the next state is not ST_RUN.

A build parameter picks the field width: 8 bits for the narrow variant, 13 bits for the wide one.

Top module: `frac_clk_en`

## Requirements
- R1: While the active-low reset is asserted the strobe is low. After reset is released with the enable high and a valid setting, the strobe pattern starts from a cleared accumulator.
- R2: Narrow variant (W=8): with madd = m − n and an msub field value of 256 − n, any window of m consecutive running cycles holds exactly n strobes.
- R3: Wide variant (W=13): with madd = m − n and an msub field value of 8192 − n, any window of m consecutive running cycles holds exactly n strobes.
- R4: From the first cycle after a clock edge that samples the enable low, the strobe stays low, and the accumulator is cleared.
- R5: The strobe is high in the first cycle after the edge that samples the enable high. For n = 1 and m = 5 the strobe then repeats every fifth cycle.
- R6: When both fields are zero and the enable is high, no strobe is produced.
- R7: Shifting both fields left by the same number of bits (the msub field becoming 2^W − (n·2^k)) leaves the strobe count per m cycles at n.
- R8: With madd = 0 and any non-zero msub field, the strobe is high in every running cycle.
- R9: Asserting reset while the block is running drives the strobe low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock whose rate is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables strobe generation |
| madd | input | W (8 or 13) | Modulo addition value, m − n |
| msub | input | W (8 or 13) | Low bits of the negative modulo subtraction value; n = 2^W − field |
| strobe | output | 1 | One-cycle enable strobe at rate n/m |

## Verification
Every result is registered once. A change of the enable or the fields takes effect on the first cycle after the rising edge that samples it, and the reset clears the strobe without waiting for an edge. The bench changes inputs and samples the strobe only on falling edges. It therefore checks the restart phase and the quiet states exactly one edge after each stimulus. Rate checks begin on the falling edge after the enabling edge and count whole multiples of m cycles. The strobe pattern has period m, so the expected count is n times the number of periods for any starting phase.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HALT = 2'd1,
        ST_RUN  = 2'd2
    } fce_state_e;

    function automatic int field_width(input bit wide);
        return wide ? 13 : 8;
    endfunction

endpackage

// File: rtl/fce_cfg_decode.sv
module fce_cfg_decode #(
    parameter int FW = 8
) (
    input  logic [FW-1:0] madd_i,
    input  logic [FW-1:0] msub_i,
    output logic          cfg_ok_o,
    output logic [FW+1:0] sub_ext_o,
    output logic [FW+1:0] add_ext_o
);
    localparam int XW = FW + 2;

    // Both fields zero is the one illegal setting.
    always_comb begin
        cfg_ok_o = (|madd_i) || (|msub_i);
    end

    // Subtraction value: upper two bits forced to ones gives msub - 2^FW.
    always_comb begin
        sub_ext_o = {2'b11, msub_i};
        add_ext_o = {2'b00, madd_i};
    end

    initial begin
        if (XW != FW + 2) $display("fce_cfg_decode: width mismatch");
    end
endmodule

// File: rtl/fce_ctrl.sv
module fce_ctrl
    import fce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       cfg_ok_i,
    output fce_state_e state_o,
    output logic       run_nx_o
);
    fce_state_e state_q;
    fce_state_e state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i && cfg_ok_i)  state_d = ST_RUN;   // T_START
                else if (en_i)         state_d = ST_HALT;  // T_REJECT
            end
            ST_HALT: begin
                if (!en_i)             state_d = ST_OFF;   // T_ABORT
                else if (cfg_ok_i)     state_d = ST_RUN;   // T_RECOVER
            end
            ST_RUN: begin
                if (!en_i)             state_d = ST_OFF;   // T_STOP
                else if (!cfg_ok_i)    state_d = ST_HALT;  // T_FAULT
            end
            default:                   state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        state_o  = state_q;
        run_nx_o = (state_d == ST_RUN);
    end

    // R4: running is only reached from an enabled, valid setting.
    a_r4_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> $past(en_i && cfg_ok_i));

    // R6: the halt state is only held while the setting was invalid.
    a_r6_halt_from_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> $past(en_i && !cfg_ok_i));
endmodule

// File: rtl/fce_accum.sv
module fce_accum #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [FW+1:0] sub_ext_i,
    input  logic [FW+1:0] add_ext_i,
    output logic          strobe_o
);
    localparam int AW = FW + 1;
    localparam int XW = FW + 2;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;
    logic          strobe_q;
    logic          strobe_d;
    logic [XW-1:0] trial;
    logic [XW-1:0] refill;

    always_comb begin
        trial  = {1'b0, acc_q} + sub_ext_i;
        refill = {1'b0, acc_q} + add_ext_i;
        if (!step_i) begin
            acc_d    = '0;
            strobe_d = 1'b0;
        end else if (trial[XW-1]) begin
            acc_d    = refill[AW-1:0];
            strobe_d = 1'b1;
        end else begin
            acc_d    = trial[AW-1:0];
            strobe_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            strobe_q <= strobe_d;
        end
    end

    always_comb strobe_o = strobe_q;

    // R4: after a cycle with stepping withheld the accumulator restarts at zero.
    a_r4_cleared_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!step_i) |-> (acc_q == '0) && !strobe_q);
endmodule

// File: rtl/frac_clk_en.sv
module frac_clk_en
    import fce_pkg::*;
#(
    parameter bit WIDE = 1'b0,
    localparam int FW = fce_pkg::field_width(WIDE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [FW-1:0] madd,
    input  logic [FW-1:0] msub,
    output logic          strobe
);
    logic          cfg_ok;
    logic [FW+1:0] sub_ext;
    logic [FW+1:0] add_ext;
    fce_state_e    state;
    logic          run_nx;
    logic          strobe_raw;

    fce_cfg_decode #(.FW(FW)) u_dec (
        .madd_i    (madd),
        .msub_i    (msub),
        .cfg_ok_o  (cfg_ok),
        .sub_ext_o (sub_ext),
        .add_ext_o (add_ext)
    );

    fce_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .cfg_ok_i (cfg_ok),
        .state_o  (state),
        .run_nx_o (run_nx)
    );

    fce_accum #(.FW(FW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (run_nx),
        .sub_ext_i (sub_ext),
        .add_ext_i (add_ext),
        .strobe_o  (strobe_raw)
    );

    assign strobe = strobe_raw;

    // R4: no strobe while off.
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !strobe);

    // R6: no strobe while halted on an invalid setting.
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !strobe);

    // R5: entering run always yields a strobe in the first running cycle.
    a_r5_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> strobe);
endmodule

// File: tb/tb_frac_clk_en.sv
module tb_frac_clk_en;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b0, en_w = 1'b0;
    logic [7:0]  madd_n = '0, msub_n = '0;
    logic [12:0] madd_w = '0, msub_w = '0;
    logic        stb_n, stb_w;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    frac_clk_en #(.WIDE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .en(en_n),
        .madd(madd_n), .msub(msub_n), .strobe(stb_n));

    frac_clk_en #(.WIDE(1'b1)) dut_wide (
        .clk(clk), .rst_n(rst_n), .en(en_w),
        .madd(madd_w), .msub(msub_w), .strobe(stb_w));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Program, enable, count over p*m cycles, disable.
    task automatic rate_run(input bit wide, input int n, input int m, input int k,
                            input int p, input string req);
        int cnt = 0;
        int fw = wide ? 13 : 8;
        int nv = n << k;
        int av = (m - n) << k;
        int sv = ((1 << fw) - nv) & ((1 << fw) - 1);
        @(negedge clk);
        en_n = 1'b0; en_w = 1'b0;
        if (wide) begin madd_w = 13'(av); msub_w = 13'(sv); end
        else      begin madd_n = 8'(av);  msub_n = 8'(sv);  end
        @(negedge clk);
        if (wide) en_w = 1'b1; else en_n = 1'b1;
        for (int c = 0; c < p * m; c++) begin
            @(negedge clk);
            cnt += wide ? int'(stb_w) : int'(stb_n);
        end
        check(cnt == n * p, req, cnt, n * p);
        en_n = 1'b0; en_w = 1'b0;
    endtask

    initial begin
        int cnt;
        // R1: strobe low during reset
        #1;
        check(stb_n == 1'b0, "R1", int'(stb_n), 0);
        repeat (3) @(negedge clk);
        check(stb_n == 1'b0 && stb_w == 1'b0, "R1", int'(stb_n | stb_w), 0);
        rst_n = 1'b1;

        // R2: near-exhaustive narrow sweep
        for (int m = 1; m <= 10; m++)
            for (int n = 1; n <= m; n++)
                rate_run(1'b0, n, m, 0, 3, "R2");
        rate_run(1'b0, 200, 255, 0, 2, "R2");
        rate_run(1'b0, 1, 256, 0, 1, "R2");

        // R3: wide variant
        rate_run(1'b1, 1, 2, 0, 4, "R3");
        rate_run(1'b1, 7, 13, 0, 3, "R3");
        rate_run(1'b1, 4000, 8000, 0, 1, "R3");
        rate_run(1'b1, 8191, 16382, 0, 1, "R3");

        // R7: scaled settings
        rate_run(1'b0, 1, 3, 2, 3, "R7");
        rate_run(1'b0, 3, 8, 3, 2, "R7");
        rate_run(1'b0, 5, 7, 1, 2, "R7");
        rate_run(1'b1, 3, 5, 10, 3, "R7");

        // R8: madd zero gives full rate
        @(negedge clk);
        madd_n = 8'd0; msub_n = 8'd251; en_n = 1'b1;
        cnt = 0;
        for (int c = 0; c < 20; c++) begin @(negedge clk); cnt += int'(stb_n); end
        check(cnt == 20, "R8", cnt, 20);

        // R4: enable low silences from the next cycle
        en_n = 1'b0;
        cnt = 0;
        for (int c = 0; c < 10; c++) begin @(negedge clk); cnt += int'(stb_n); end
        check(cnt == 0, "R4", cnt, 0);

        // R5: restart phase for n=1, m=5 (pattern 1,0,0,0,0,1)
        madd_n = 8'd4; msub_n = 8'd255; en_n = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(stb_n == ((c == 0 || c == 5) ? 1'b1 : 1'b0), "R5",
                  int'(stb_n), (c == 0 || c == 5) ? 1 : 0);
        end
        // R4: disable mid-pattern then restart gives the same phase
        @(negedge clk); en_n = 1'b0;
        @(negedge clk); check(stb_n == 1'b0, "R4", int'(stb_n), 0);
        en_n = 1'b1;
        @(negedge clk); check(stb_n == 1'b1, "R4", int'(stb_n), 1);
        @(negedge clk); check(stb_n == 1'b0, "R4", int'(stb_n), 0);

        // R6: both fields zero
        madd_n = 8'd0; msub_n = 8'd0;
        cnt = 0;
        for (int c = 0; c < 40; c++) begin @(negedge clk); cnt += int'(stb_n); end
        check(cnt == 0, "R6", cnt, 0);
        // R6: leaving the invalid setting resumes at the first-strobe phase
        madd_n = 8'd4; msub_n = 8'd255;
        @(negedge clk); check(stb_n == 1'b1, "R6", int'(stb_n), 1);

        // R9: asynchronous reset mid-run
        madd_n = 8'd0; msub_n = 8'd200;
        repeat (3) @(negedge clk);
        check(stb_n == 1'b1, "R9", int'(stb_n), 1);
        #1 rst_n = 1'b0;
        #0.5 check(stb_n == 1'b0, "R9", int'(stb_n), 0);
        @(negedge clk); rst_n = 1'b1;
        madd_n = 8'd4; msub_n = 8'd255;
        // R1: after release the pattern starts from a cleared accumulator
        @(negedge clk); check(stb_n == 1'b1, "R1", int'(stb_n), 1);
        @(negedge clk); check(stb_n == 1'b0, "R1", int'(stb_n), 0);
        en_n = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule